// File: doc/BRIEF.md
# Multi-Channel Voltage Monitor Sequencer

This block drives the scan of a six-way analog multiplexer feeding a 10-bit converter. The converter is reached through a simple handshake: the block raises a one-cycle start strobe, and the converter later returns a done strobe together with a result. Each result is written into the result register of the channel that was selected. It is then compared against that channel's overvoltage and undervoltage limits.

A channel whose 2-bit range code is 11 is left out of the scan completely. When a reading is out of limits, the sequencer keeps the multiplexer on that channel and converts it again. A fault is declared only after a run of consecutive out-of-limit readings whose length is set by a 2-bit deglitch field. Declared faults set sticky per-channel flags and emit a one-cycle event pulse, except in margining mode, where nothing is recorded. Software clears the flags with write-one-to-clear strobes.

Top module: `vmon_seq`

## Requirements
- R1: A conversion is started only while both `en_pin` and `sw_en` are 1. While either is 0, `adc_start` stays 0.
- R2: Channels are visited in ascending index order among the enabled ones, wrapping from the highest back to the lowest. A channel whose range code in `range_cfg[2i+1:2i]` is 2'b11 is never selected for a conversion. Codes 00, 01 and 10 leave the channel enabled.
- R3: On each `adc_done`, `adc_result` is stored into the result field `results[RW*i +: RW]` of the converted channel `i`.
- R4: A reading strictly greater than the channel's OV limit is an overvoltage excursion. A reading strictly less than its UV limit is an undervoltage excursion. A reading equal to either limit is within limits.
- R5: After an out-of-limit reading, the next conversion is on the same channel, with no other channel in between.
- R6: A fault is declared when the number of consecutive out-of-limit readings on one channel reaches N. N is 1, 2, 4 or 8 for `dg_sel` equal to 00, 01, 10 or 11. The scan then moves to the next enabled channel.
- R7: If a reading within limits arrives during a deglitch run, the run is abandoned, no fault is declared, and the scan continues at the next enabled channel.
- R8: While `margin_mode` is 1, declared faults set no flag and produce no `fault_pulse`.
- R9: Bit i of `ov_flags` and `uv_flags` is sticky until a 1 is written to bit i of `clr_ov` or `clr_uv`. A fault set in the same cycle as a clear wins.
- R10: `fault_pulse` is high for exactly one cycle, in the cycle after each recorded fault, together with the updated flag.
- R11: After reset, all flags and results are 0, `adc_start` and `fault_pulse` are 0, and `mux_sel` is 0.
- R12: `adc_start` is a single-cycle strobe, and no new conversion starts while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| margin_mode | input | 1 | Suppresses fault recording |
| dg_sel | input | 2 | Deglitch length select |
| range_cfg | input | 2*NCH | Per-channel range code, 11 = skipped |
| ov_thr | input | RW*NCH | Per-channel overvoltage limits |
| uv_thr | input | RW*NCH | Per-channel undervoltage limits |
| clr_ov | input | NCH | Write-one-to-clear for OV flags |
| clr_uv | input | NCH | Write-one-to-clear for UV flags |
| adc_done | input | 1 | Conversion complete strobe |
| adc_result | input | RW | Conversion result |
| adc_start | output | 1 | Conversion start strobe |
| mux_sel | output | CW | Multiplexer channel select |
| results | output | RW*NCH | Per-channel last result |
| ov_flags | output | NCH | Sticky overvoltage flags |
| uv_flags | output | NCH | Sticky undervoltage flags |
| fault_pulse | output | 1 | One-cycle fault event |

## Verification
The scan is first run with every channel in limits and with two channels disabled. These runs separate a correct skip-and-wrap order from one that visits disabled inputs. Readings placed exactly on a limit and one count beyond it separate strict from inclusive comparison. Persistent excursions under every deglitch setting show whether the hold length matches 1, 2, 4 or 8. A short glitch under the longest setting separates abandoning the run from declaring a fault. Margining and clear strobes separate recording from suppression and stickiness from self-clearing.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;

  localparam logic [1:0] RANGE_OFF = 2'b11;
  localparam int         DG_MAX    = 8;

  // consecutive out-of-limit readings needed for a fault
  function automatic int dg_need(input logic [1:0] code);
    return 1 << code;
  endfunction

  function automatic logic chan_on(input logic [1:0] code);
    return code != RANGE_OFF;
  endfunction

  function automatic logic above(input logic [15:0] val, input logic [15:0] lim);
    return val > lim;
  endfunction

  function automatic logic below(input logic [15:0] val, input logic [15:0] lim);
    return val < lim;
  endfunction

endpackage

// File: rtl/vmon_chsel.sv
module vmon_chsel
  import vmon_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 3
) (
  input  logic [2*NCH-1:0] range_cfg,
  input  logic [CW-1:0]    from_ch,
  output logic [CW-1:0]    nxt_ch,
  output logic             any_en
);
  logic [NCH-1:0] en_vec;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_en
      assign en_vec[gi] = chan_on(range_cfg[2*gi +: 2]);
    end
  endgenerate

  // first enabled channel strictly after from_ch, wrapping around
  always_comb begin
    any_en = 1'b0;
    nxt_ch = from_ch;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (int'(from_ch) + k) % NCH;
      if (!any_en && en_vec[idx]) begin
        any_en = 1'b1;
        nxt_ch = CW'(idx);
      end
    end
  end
endmodule

// File: rtl/vmon_limit_chk.sv
module vmon_limit_chk
  import vmon_pkg::*;
#(
  parameter int NCH = 6,
  parameter int RW  = 10,
  parameter int CW  = 3
) (
  input  logic [RW-1:0]     value,
  input  logic [CW-1:0]     ch,
  input  logic [RW*NCH-1:0] ov_thr,
  input  logic [RW*NCH-1:0] uv_thr,
  output logic              over,
  output logic              under
);
  logic [RW-1:0] ov_lim;
  logic [RW-1:0] uv_lim;

  assign ov_lim = ov_thr[int'(ch)*RW +: RW];
  assign uv_lim = uv_thr[int'(ch)*RW +: RW];
  assign over   = above(16'(value), 16'(ov_lim));
  assign under  = below(16'(value), 16'(uv_lim));
endmodule

// File: rtl/vmon_result_bank.sv
module vmon_result_bank #(
  parameter int NCH = 6,
  parameter int RW  = 10,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [RW-1:0]     wr_data,
  output logic [RW*NCH-1:0] results
);
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_res
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          results[RW*gi +: RW] <= '0;
        else if (wr_en && (int'(wr_ch) == gi))
          results[RW*gi +: RW] <= wr_data;
      end
    end
  endgenerate
endmodule

// File: rtl/vmon_flag_bank.sv
module vmon_flag_bank #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_ov,
  input  logic [NCH-1:0] set_uv,
  input  logic [NCH-1:0] clr_ov,
  input  logic [NCH-1:0] clr_uv,
  output logic [NCH-1:0] ov_flags,
  output logic [NCH-1:0] uv_flags
);
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_flag
      // set takes priority over a simultaneous clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ov_flags[gi] <= 1'b0;
          uv_flags[gi] <= 1'b0;
        end else begin
          ov_flags[gi] <= set_ov[gi] | (ov_flags[gi] & ~clr_ov[gi]);
          uv_flags[gi] <= set_uv[gi] | (uv_flags[gi] & ~clr_uv[gi]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/vmon_seq.sv
module vmon_seq
  import vmon_pkg::*;
#(
  parameter int NCH = 6,
  parameter int RW  = 10,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic              sw_en,
  input  logic              margin_mode,
  input  logic [1:0]        dg_sel,
  input  logic [2*NCH-1:0]  range_cfg,
  input  logic [RW*NCH-1:0] ov_thr,
  input  logic [RW*NCH-1:0] uv_thr,
  input  logic [NCH-1:0]    clr_ov,
  input  logic [NCH-1:0]    clr_uv,
  input  logic              adc_done,
  input  logic [RW-1:0]     adc_result,
  output logic              adc_start,
  output logic [CW-1:0]     mux_sel,
  output logic [RW*NCH-1:0] results,
  output logic [NCH-1:0]    ov_flags,
  output logic [NCH-1:0]    uv_flags,
  output logic              fault_pulse
);
  localparam int SW = $clog2(DG_MAX + 1);

  sq_state_t      state;
  logic [CW-1:0]  cur_ch;
  logic [SW-1:0]  streak;

  // named internal events
  logic           run;
  logic           conv_done;
  logic           eval;
  logic           over, under, excursion;
  logic           streak_last;
  logic           hold;
  logic           fault_decl;
  logic           record;
  logic [CW-1:0]  nxt_ch, first_ch;
  logic           any_en, any_en_first;
  logic [NCH-1:0] set_ov, set_uv;

  assign run       = en_pin & sw_en;
  assign conv_done = (state == SQ_WAIT) & adc_done;
  assign eval      = conv_done & run;
  assign excursion = over | under;
  assign streak_last = (int'(streak) + 1) >= dg_need(dg_sel);
  assign hold       = eval & excursion & ~streak_last;
  assign fault_decl = eval & excursion & streak_last;
  assign record     = fault_decl & ~margin_mode;

  assign adc_start = (state == SQ_START) & run;
  assign mux_sel   = cur_ch;

  vmon_chsel #(.NCH(NCH), .CW(CW)) u_next (
    .range_cfg (range_cfg),
    .from_ch   (cur_ch),
    .nxt_ch    (nxt_ch),
    .any_en    (any_en)
  );

  vmon_chsel #(.NCH(NCH), .CW(CW)) u_first (
    .range_cfg (range_cfg),
    .from_ch   (CW'(NCH - 1)),
    .nxt_ch    (first_ch),
    .any_en    (any_en_first)
  );

  vmon_limit_chk #(.NCH(NCH), .RW(RW), .CW(CW)) u_lim (
    .value  (adc_result),
    .ch     (cur_ch),
    .ov_thr (ov_thr),
    .uv_thr (uv_thr),
    .over   (over),
    .under  (under)
  );

  vmon_result_bank #(.NCH(NCH), .RW(RW), .CW(CW)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (conv_done),
    .wr_ch   (cur_ch),
    .wr_data (adc_result),
    .results (results)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_set
      assign set_ov[gi] = record & over  & (int'(cur_ch) == gi);
      assign set_uv[gi] = record & under & (int'(cur_ch) == gi);
    end
  endgenerate

  vmon_flag_bank #(.NCH(NCH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ov   (set_ov),
    .set_uv   (set_uv),
    .clr_ov   (clr_ov),
    .clr_uv   (clr_uv),
    .ov_flags (ov_flags),
    .uv_flags (uv_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      cur_ch      <= '0;
      streak      <= '0;
      fault_pulse <= 1'b0;
    end else begin
      fault_pulse <= record;
      unique case (state)
        SQ_IDLE: begin
          streak <= '0;
          if (run && any_en_first) begin
            cur_ch <= first_ch;
            state  <= SQ_START;
          end
        end
        SQ_START: state <= run ? SQ_WAIT : SQ_IDLE;
        SQ_WAIT: begin
          if (adc_done) begin
            if (!run) begin
              state <= SQ_IDLE;
            end else if (hold) begin
              streak <= streak + 1'b1;
              state  <= SQ_START;
            end else begin
              streak <= '0;
              if (any_en) begin
                cur_ch <= nxt_ch;
                state  <= SQ_START;
              end else begin
                state <= SQ_IDLE;
              end
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vmon_seq_chk.sv
module vmon_seq_chk #(
  parameter int NCH = 6,
  parameter int RW  = 10,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_pin,
  input logic             sw_en,
  input logic             margin_mode,
  input logic [2*NCH-1:0] range_cfg,
  input logic [NCH-1:0]   clr_ov,
  input logic [NCH-1:0]   clr_uv,
  input logic             adc_start,
  input logic [CW-1:0]    mux_sel,
  input logic [NCH-1:0]   ov_flags,
  input logic [NCH-1:0]   uv_flags,
  input logic             fault_pulse,
  input logic             fault_decl
);
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_pin && sw_en) |-> !adc_start);

  a_r2_skip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (range_cfg[int'(mux_sel)*2 +: 2] != 2'b11));

  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r8_margin_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    margin_mode |=> !fault_pulse);

  a_r8_margin_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    margin_mode |=> (((ov_flags & ~$past(ov_flags)) == '0) &&
                     ((uv_flags & ~$past(uv_flags)) == '0)));

  a_r9_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ov == '0) |=> (($past(ov_flags) & ~ov_flags) == '0));

  a_r9_uv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_uv == '0) |=> (($past(uv_flags) & ~uv_flags) == '0));

  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  a_r10_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> ((ov_flags | uv_flags) != '0));

  a_r10_decl_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_decl && !margin_mode) |=> fault_pulse);
endmodule

bind vmon_seq vmon_seq_chk #(.NCH(NCH), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_pin      (en_pin),
  .sw_en       (sw_en),
  .margin_mode (margin_mode),
  .range_cfg   (range_cfg),
  .clr_ov      (clr_ov),
  .clr_uv      (clr_uv),
  .adc_start   (adc_start),
  .mux_sel     (mux_sel),
  .ov_flags    (ov_flags),
  .uv_flags    (uv_flags),
  .fault_pulse (fault_pulse),
  .fault_decl  (fault_decl)
);

// File: tb/vmon_seq_tb.sv
module vmon_seq_tb;
  localparam int NCH = 6;
  localparam int RW  = 10;
  localparam int CW  = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic en_pin = 0, sw_en = 0, margin_mode = 0;
  logic [1:0] dg_sel = 0;
  logic [2*NCH-1:0] range_cfg = '0;
  logic [RW*NCH-1:0] ov_thr, uv_thr;
  logic [NCH-1:0] clr_ov = '0, clr_uv = '0;
  logic adc_done = 0;
  logic [RW-1:0] adc_result = '0;
  logic adc_start;
  logic [CW-1:0] mux_sel;
  logic [RW*NCH-1:0] results;
  logic [NCH-1:0] ov_flags, uv_flags;
  logic fault_pulse;

  always #2 clk = ~clk;

  vmon_seq #(.NCH(NCH), .RW(RW)) u_dut (.*);

  int checks = 0, failures = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- ADC plant ----------------
  int vin[NCH];
  int glitch_n[NCH];
  int glitch_v[NCH];
  bit busy = 0;
  int cnt = 0, ach = 0;
  int last_ch = -1, run_len = 0;
  int maxrun[NCH];
  int overlap = 0, bad_start = 0, pulse_cnt = 0, after5 = -1;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0;
      adc_done = 0;
    end else begin
      adc_done = 0;
      if (busy) begin
        cnt--;
        if (cnt == 0) begin
          busy = 0;
          adc_done = 1;
          if (glitch_n[ach] > 0) begin
            adc_result = RW'(glitch_v[ach]);
            glitch_n[ach]--;
          end else adc_result = RW'(vin[ach]);
        end
      end
      if (adc_start) begin
        if (busy) overlap++;
        busy = 1; cnt = 3; ach = int'(mux_sel);
        if (range_cfg[ach*2 +: 2] == 2'b11) bad_start++;
        if (last_ch == 5 && ach != 5) after5 = ach;
        if (ach == last_ch) run_len++; else run_len = 1;
        last_ch = ach;
        if (run_len > maxrun[ach]) maxrun[ach] = run_len;
      end
      if (fault_pulse) pulse_cnt++;
    end
  end

  // ---------------- reference model ----------------
  int mst = 0, mch = 0, mstreak = 0;
  int mres[NCH];
  bit [NCH-1:0] mov = 0, muv = 0;
  bit mpulse = 0;

  function automatic bit m_on(int c);
    return range_cfg[c*2 +: 2] != 2'b11;
  endfunction

  function automatic int m_next(int c);
    for (int k = 1; k <= NCH; k++) if (m_on((c + k) % NCH)) return (c + k) % NCH;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mch = 0; mstreak = 0; mov = 0; muv = 0; mpulse = 0;
      foreach (mres[i]) mres[i] = 0;
    end else begin
      bit go;
      bit [NCH-1:0] sov, suv;
      go = en_pin && sw_en;
      sov = 0; suv = 0; mpulse = 0;
      if (mst == 0) begin
        mstreak = 0;
        if (go && m_next(NCH - 1) >= 0) begin mch = m_next(NCH - 1); mst = 1; end
      end else if (mst == 1) begin
        mst = go ? 2 : 0;
      end else if (adc_done) begin
        mres[mch] = int'(adc_result);
        if (!go) mst = 0;
        else begin
          int r, ov, uv;
          r = int'(adc_result);
          ov = int'(ov_thr[mch*RW +: RW]);
          uv = int'(uv_thr[mch*RW +: RW]);
          if (r > ov || r < uv) begin
            mstreak++;
            if (mstreak >= (1 << dg_sel)) begin
              if (!margin_mode) begin
                sov[mch] = (r > ov); suv[mch] = (r < uv); mpulse = 1;
              end
              mstreak = 0;
              if (m_next(mch) >= 0) begin mch = m_next(mch); mst = 1; end else mst = 0;
            end else mst = 1;
          end else begin
            mstreak = 0;
            if (m_next(mch) >= 0) begin mch = m_next(mch); mst = 1; end else mst = 0;
          end
        end
      end
      mov = sov | (mov & ~clr_ov);
      muv = suv | (muv & ~clr_uv);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R1/R12 adc_start", int'(adc_start), int'(mst == 1 && en_pin && sw_en));
      chk("R2/R5/R7 mux_sel", int'(mux_sel), mch);
      for (int i = 0; i < NCH; i++)
        chk("R3 result", int'(results[i*RW +: RW]), mres[i]);
      chk("R4/R6/R9 ov_flags", int'(ov_flags), int'(mov));
      chk("R4/R6/R9 uv_flags", int'(uv_flags), int'(muv));
      chk("R10 fault_pulse", int'(fault_pulse), int'(mpulse));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_runs();
    foreach (maxrun[i]) maxrun[i] = 0;
    last_ch = -1; run_len = 0;
  endtask

  task automatic quiesce();
    sw_en = 0;
    step(20);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      ov_thr[i*RW +: RW] = RW'(800);
      uv_thr[i*RW +: RW] = RW'(200);
      vin[i] = 300 + 40 * i;
      glitch_n[i] = 0; glitch_v[i] = 0; maxrun[i] = 0;
    end
    step(3);
    // R11 reset state
    chk("R11 adc_start", int'(adc_start), 0);
    chk("R11 mux_sel", int'(mux_sel), 0);
    chk("R11 flags", int'(ov_flags | uv_flags), 0);
    chk("R11 results", int'(results != '0), 0);
    chk("R11 fault_pulse", int'(fault_pulse), 0);
    rst_n = 1;
    step(2);

    // R1: one enable missing -> no start
    en_pin = 0; sw_en = 1; step(60);
    chk("R1 no start en_pin low", maxrun[0] + maxrun[1], 0);
    en_pin = 1; sw_en = 0; step(60);
    chk("R1 no start sw_en low", maxrun[0] + maxrun[1], 0);

    // R2/R3 all channels in limits
    sw_en = 1; step(200);
    for (int i = 0; i < NCH; i++)
      chk("R3 stored value", int'(results[i*RW +: RW]), vin[i]);
    chk("R4 no fault in range", int'(ov_flags | uv_flags), 0);

    // R2 disabled channels 1 and 4
    quiesce();
    range_cfg[3:2] = 2'b11; range_cfg[9:8] = 2'b11; range_cfg[5:4] = 2'b10;
    bad_start = 0; clear_runs();
    sw_en = 1; step(200);
    chk("R2 disabled never started", bad_start, 0);
    chk("R2 enabled visited", int'(maxrun[5] > 0 && maxrun[0] > 0), 1);
    quiesce();
    range_cfg = '0;
    sw_en = 1;

    // R4 boundary: equal to limits is not a fault
    dg_sel = 2'b00;
    vin[2] = 800; vin[3] = 200; step(200);
    chk("R4 equal limit no OV", int'(ov_flags[2]), 0);
    chk("R4 equal limit no UV", int'(uv_flags[3]), 0);
    pulse_cnt = 0;
    vin[2] = 801; vin[3] = 199; step(200);
    chk("R4 OV set", int'(ov_flags[2]), 1);
    chk("R4 UV set", int'(uv_flags[3]), 1);
    chk("R10 pulses seen", int'(pulse_cnt > 0), 1);

    // R9 sticky, then write-one-to-clear
    vin[2] = 500; vin[3] = 500; step(200);
    chk("R9 OV sticky", int'(ov_flags[2]), 1);
    clr_ov[2] = 1; clr_uv[3] = 1; step(1);
    clr_ov = '0; clr_uv = '0; step(2);
    chk("R9 OV cleared", int'(ov_flags[2]), 0);
    chk("R9 UV cleared", int'(uv_flags[3]), 0);

    // R5/R6 deglitch lengths with persistent excursion
    for (int d = 0; d < 4; d++) begin
      quiesce();
      dg_sel = 2'(d); vin[3] = 100; clear_runs();
      sw_en = 1; step(400);
      chk("R6 hold length", maxrun[3], 1 << d);
      chk("R5 UV after deglitch", int'(uv_flags[3]), 1);
      clr_uv[3] = 1; step(1); clr_uv = '0;
    end
    vin[3] = 500; step(60);

    // R7 glitch shorter than deglitch window
    quiesce();
    dg_sel = 2'b11; clear_runs(); after5 = -1;
    clr_uv = '1; step(1); clr_uv = '0;
    glitch_v[5] = 100; glitch_n[5] = 2;
    sw_en = 1; step(300);
    chk("R7 run abandoned length", maxrun[5], 3);
    chk("R7 no flag", int'(uv_flags[5]), 0);
    chk("R7 resumes at next", after5, 0);

    // R8 margining suppresses recording
    quiesce();
    margin_mode = 1; dg_sel = 2'b01; vin[1] = 900; pulse_cnt = 0;
    sw_en = 1; step(300);
    chk("R8 no OV flag", int'(ov_flags[1]), 0);
    chk("R8 no pulse", pulse_cnt, 0);
    margin_mode = 0; step(300);
    chk("R8 recorded after margin off", int'(ov_flags[1]), 1);

    chk("R12 no overlap", overlap, 0);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule